// File: doc/BRIEF.md
# Serial Configuration Slave with Read Unlock

This block is the digital control port of a two-stage sensor amplifier front end. An external controller talks to it over a three-wire serial link: a serial clock, an active-low select, and one bidirectional data line. Here the data line is split into an input, an output and an output enable, and the pad sits outside the block. Every transfer is sixteen clock periods long. A command byte comes first and a data byte follows. The slave keeps a configuration byte and an offset-code byte, and it drives their fields straight to the analog stages as plain level outputs.

After reset the port accepts writes only. Readback is turned on by writing a two-byte key to a dedicated key register in two writes in a row. Once readback is on, the slave takes over the data line in the middle of a read frame and hands it back at the end of the frame. The serial pins are oversampled in the system clock domain, so the block has a single clock.

No pin carries a data stream, so there is no valid/ready pair and no back-pressure. The external controller sets the pace of every transfer, and every output is a plain level.

Top module: `afe_spi_regs`

## Requirements
- R1: After reset the configuration byte is 0x00, the offset code is 0x80, readback is off, and `sdio_oe` is low.
- R2: A frame is 16 bits sampled on rising serial clock edges, MSB first. The command byte carries read (1) or write (0) in bit 7, zeros in bits 6:4, and the register address in bits 3:0. The data byte follows the command byte.
- R3: A write to address 0x0 sets the configuration byte. Its fields are: bit 7 `in_sel`, bit 6 `stage1_en`, bit 5 `stage2_en`, bit 4 `filt_ext`, bit 3 `cm_hi`, bits 2:1 `gain2_code`, bit 0 `gain1_low`.
- R4: A write to address 0x1 sets the 8-bit `dac_code`.
- R5: A write takes effect only after its 16th rising edge, as a one-cycle update. A frame cut short by the select going high changes nothing.
- R6: Readback turns on when the key register (0xF) receives 0xFE and then 0xED in the next write. Any other value written to 0xF turns readback off. Writing 0xFE also turns it off and arms the key. Any write in between disarms the key.
- R7: While readback is on, a read of 0x0 or 0x1 raises `sdio_oe` on the falling edge that follows the 8th rising edge. From that edge the register is shifted out MSB first, with one new bit on each falling edge.
- R8: `sdio_oe` drops after the 16th rising edge or when the select goes high, whichever comes first.
- R9: A read while readback is off leaves `sdio_oe` low and changes no state.
- R10: Nonzero command bits 6:4, an address other than 0x0, 0x1 or 0xF, or a read of 0xF: each makes the frame ignored, with no write and no output drive.
- R11: A falling select always restarts the frame at bit 0. With the select held low, frames follow one another every 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Read data toward the pad |
| sdio_oe | output | 1 | Pad output enable |
| in_sel | output | 1 | Sensor input select |
| stage1_en | output | 1 | First amplifier stage enable |
| stage2_en | output | 1 | Second amplifier stage enable |
| filt_ext | output | 1 | Route between stages through the external filter |
| cm_hi | output | 1 | High common-mode level select |
| gain2_code | output | 2 | Second-stage gain code |
| gain1_low | output | 1 | First stage in low-gain setting |
| dac_code | output | 8 | Offset DAC code |

## Verification
A bit counter that is off by one shows up after the next write's 16th edge: the target register holds a shifted byte, or it keeps its old value. A wrong key state is only seen at the next read. There, `sdio_oe` either rises or stays low during bits 9 to 16, which is why the bench reads right after every key sequence and right after every abort. A stale enable after an abort shows at the pad within a few system cycles of the select rising, and the bench samples `sdio_oe` at that point.

// File: rtl/afe_spi_pkg.sv
package afe_spi_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int FRAME_BITS = 2 * DW;

  localparam logic [AW-1:0] ADDR_CFG = 4'h0;
  localparam logic [AW-1:0] ADDR_DAC = 4'h1;
  localparam logic [AW-1:0] ADDR_KEY = 4'hF;

  localparam logic [DW-1:0] CFG_RST    = 8'h00;
  localparam logic [DW-1:0] DAC_RST    = 8'h80;
  localparam logic [DW-1:0] KEY_FIRST  = 8'hFE;
  localparam logic [DW-1:0] KEY_SECOND = 8'hED;

  typedef struct packed {
    logic       in_sel;
    logic       stage1_en;
    logic       stage2_en;
    logic       filt_ext;
    logic       cm_hi;
    logic [1:0] gain2_code;
    logic       gain1_low;
  } cfg_t;

  // True when the command is legal for its direction: reserved bits clear, address mapped.
  function automatic logic cmd_ok(input logic [DW-1:0] cmd);
    logic [AW-1:0] a;
    a = cmd[AW-1:0];
    if (cmd[DW-2:AW] != '0) return 1'b0;
    if (cmd[DW-1]) return (a == ADDR_CFG) || (a == ADDR_DAC);
    return (a == ADDR_CFG) || (a == ADDR_DAC) || (a == ADDR_KEY);
  endfunction
endpackage

// File: rtl/afe_spi_sync.sv
module afe_spi_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter int EDGE_N = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      din,
  output logic [N-1:0]      dout,
  output logic [EDGE_N-1:0] rise,
  output logic [EDGE_N-1:0] fall
);
  logic [STAGES-1:0][N-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {STAGES{RST_VAL}};
    else        pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];

  for (genvar i = 0; i < EDGE_N; i++) begin : g_edge
    logic hist;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= RST_VAL[i];
      else        hist <= pipe[STAGES-1][i];
    end
    assign rise[i] =  pipe[STAGES-1][i] & ~hist;
    assign fall[i] = ~pipe[STAGES-1][i] &  hist;
  end
endmodule

// File: rtl/afe_spi_frame.sv
module afe_spi_frame
  import afe_spi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_hi,
  input  logic          cs_rise,
  input  logic          cs_fall,
  input  logic          sclk_rise,
  input  logic          sclk_fall,
  input  logic          din,
  input  logic          read_en,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sdo,
  output logic          oe
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] CMD_LAST = CW'(DW - 1);
  localparam logic [CW-1:0] DATA_FIRST = CW'(DW);

  logic [CW-1:0] cnt;
  logic [DW-1:0] shift_q, cmd_q, out_q;
  logic [DW-1:0] next_byte;

  assign next_byte = {shift_q[DW-2:0], din};
  assign rd_addr   = cmd_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; shift_q <= '0; cmd_q <= '0; out_q <= '0;
      wr_stb <= 1'b0; wr_addr <= '0; wr_data <= '0; sdo <= 1'b0; oe <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (cs_hi || cs_rise || cs_fall) begin
        cnt <= '0;
        oe  <= 1'b0;
      end else if (sclk_rise) begin
        shift_q <= next_byte;
        if (cnt == LAST_BIT) begin
          cnt <= '0;
          oe  <= 1'b0;
          if (!cmd_q[DW-1] && cmd_ok(cmd_q)) begin
            wr_stb  <= 1'b1;
            wr_addr <= cmd_q[AW-1:0];
            wr_data <= next_byte;
          end
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == CMD_LAST) cmd_q <= next_byte;
        end
      end else if (sclk_fall && cnt >= DATA_FIRST) begin
        if (cnt == DATA_FIRST) begin
          if (cmd_q[DW-1] && cmd_ok(cmd_q) && read_en) begin
            oe    <= 1'b1;
            sdo   <= rd_data[DW-1];
            out_q <= {rd_data[DW-2:0], 1'b0};
          end
        end else if (oe) begin
          sdo   <= out_q[DW-1];
          out_q <= {out_q[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/afe_spi_regfile.sv
module afe_spi_regfile
  import afe_spi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] dac_q,
  output logic          read_en
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST; dac_q <= DAC_RST; read_en <= 1'b0; armed <= 1'b0;
    end else if (wr_stb) begin
      case (wr_addr)
        ADDR_CFG: begin cfg_q <= wr_data; armed <= 1'b0; end
        ADDR_DAC: begin dac_q <= wr_data; armed <= 1'b0; end
        ADDR_KEY: begin
          if (wr_data == KEY_FIRST) begin
            armed <= 1'b1; read_en <= 1'b0;
          end else if (armed && wr_data == KEY_SECOND) begin
            armed <= 1'b0; read_en <= 1'b1;
          end else begin
            armed <= 1'b0; read_en <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_CFG: rd_data = cfg_q;
      ADDR_DAC: rd_data = dac_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/afe_spi_regs.sv
module afe_spi_regs
  import afe_spi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdio_in,
  output logic          sdio_out,
  output logic          sdio_oe,
  output logic          in_sel,
  output logic          stage1_en,
  output logic          stage2_en,
  output logic          filt_ext,
  output logic          cm_hi,
  output logic [1:0]    gain2_code,
  output logic          gain1_low,
  output logic [DW-1:0] dac_code
);
  logic [2:0] sync_q;
  logic [1:0] rise_q, fall_q;
  logic sclk_rise, sclk_fall, cs_s, cs_rise, cs_fall, din_s;
  logic wr_stb, read_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data, cfg_q;
  cfg_t cfg_f;

  afe_spi_sync #(.N(3), .STAGES(2), .EDGE_N(2), .RST_VAL(3'b011)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdio_in, cs_n, sclk}),
    .dout(sync_q), .rise(rise_q), .fall(fall_q)
  );

  assign sclk_rise = rise_q[0];
  assign sclk_fall = fall_q[0];
  assign cs_rise   = rise_q[1];
  assign cs_fall   = fall_q[1];
  assign cs_s      = sync_q[1];
  assign din_s     = sync_q[2];

  afe_spi_frame u_frame (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_s), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .din(din_s),
    .read_en(read_en), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sdo(sdio_out), .oe(sdio_oe)
  );

  afe_spi_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_q(cfg_q), .dac_q(dac_code),
    .read_en(read_en)
  );

  assign cfg_f      = cfg_t'(cfg_q);
  assign in_sel     = cfg_f.in_sel;
  assign stage1_en  = cfg_f.stage1_en;
  assign stage2_en  = cfg_f.stage2_en;
  assign filt_ext   = cfg_f.filt_ext;
  assign cm_hi      = cfg_f.cm_hi;
  assign gain2_code = cfg_f.gain2_code;
  assign gain1_low  = cfg_f.gain1_low;
endmodule

// File: rtl/afe_spi_regs_chk.sv
module afe_spi_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_hi,
  input logic       sclk_fall,
  input logic       wr_stb,
  input logic       read_en,
  input logic       sdio_oe,
  input logic [7:0] cfg_bits,
  input logic [7:0] dac_code
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R5

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({cfg_bits, dac_code, read_en})); // R5

  AST_DRIVE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> read_en); // R9

  AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !sdio_oe); // R8

  AST_DRIVE_STARTS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> $past(sclk_fall)); // R7
endmodule

bind afe_spi_regs afe_spi_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_hi(cs_s), .sclk_fall(sclk_fall),
  .wr_stb(wr_stb), .read_en(read_en), .sdio_oe(sdio_oe),
  .cfg_bits(cfg_q), .dac_code(dac_code)
);

// File: tb/afe_spi_regs_test.sv
`timescale 1ns/1ps
module afe_spi_regs_test;
  localparam int HALF = 40;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, in_sel, stage1_en, stage2_en, filt_ext, cm_hi, gain1_low;
  logic [1:0] gain2_code;
  logic [7:0] dac_code;
  logic [7:0] cfg_out;

  int checks = 0, errors = 0;
  logic [7:0] rd_byte;
  logic oe_all, oe_any, oe_end;

  always #2.5 clk = ~clk;

  afe_spi_regs uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .in_sel(in_sel), .stage1_en(stage1_en),
    .stage2_en(stage2_en), .filt_ext(filt_ext), .cm_hi(cm_hi),
    .gain2_code(gain2_code), .gain1_low(gain1_low), .dac_code(dac_code)
  );

  assign cfg_out = {in_sel, stage1_en, stage2_en, filt_ext, cm_hi, gain2_code, gain1_low};

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [7:0] dat, input int nbits, input bit raise_cs);
    logic [15:0] w;
    w = {cmd, dat};
    if (cs_n) begin cs_n = 1'b0; #HALF; end
    oe_all = 1'b1; oe_any = 1'b0; rd_byte = '0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0; sdio_in = w[15-i]; #HALF;
      if (i >= 8) begin
        rd_byte[15-i] = sdio_out;
        oe_all = oe_all & sdio_oe;
        oe_any = oe_any | sdio_oe;
      end
      sclk = 1'b1; #HALF;
    end
    oe_end = sdio_oe;
    if (raise_cs) begin cs_n = 1'b1; #HALF; end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    frame({4'h0, a}, d, 16, 1'b1);
  endtask

  task automatic rd(input logic [3:0] a);
    frame({4'h8, a}, 8'h00, 16, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1", "cfg after reset", 16'(cfg_out), 16'h00);
    chk("R1", "dac after reset", 16'(dac_code), 16'h80);
    chk("R1", "oe after reset", 16'(sdio_oe), 16'h0);
    rd(4'h0);
    chk("R1", "read locked after reset", 16'(oe_any), 16'h0);
  endtask

  task automatic t_write_cfg;
    wr(4'h0, 8'hA5);
    chk("R2", "cfg byte", 16'(cfg_out), 16'hA5);
    chk("R3", "in_sel", 16'(in_sel), 16'h1);
    chk("R3", "stage1_en", 16'(stage1_en), 16'h0);
    chk("R3", "stage2_en", 16'(stage2_en), 16'h1);
    chk("R3", "filt_ext", 16'(filt_ext), 16'h0);
    chk("R3", "cm_hi", 16'(cm_hi), 16'h0);
    chk("R3", "gain2_code", 16'(gain2_code), 16'h2);
    chk("R3", "gain1_low", 16'(gain1_low), 16'h1);
    wr(4'h0, 8'h5A);
    chk("R3", "cfg second pattern", 16'(cfg_out), 16'h5A);
  endtask

  task automatic t_write_dac;
    wr(4'h1, 8'h3C);
    chk("R4", "dac write", 16'(dac_code), 16'h3C);
    chk("R4", "cfg untouched by dac write", 16'(cfg_out), 16'h5A);
  endtask

  task automatic t_locked_read;
    rd(4'h1);
    chk("R9", "no drive while locked", 16'(oe_any), 16'h0);
    chk("R9", "dac unchanged", 16'(dac_code), 16'h3C);
  endtask

  task automatic t_unlock;
    wr(4'hF, 8'hFE);
    wr(4'hF, 8'hED);
    rd(4'h0);
    chk("R6", "unlocked drive", 16'(oe_all), 16'h1);
    chk("R7", "read cfg", 16'(rd_byte), 16'h5A);
    chk("R8", "released after 16th edge", 16'(oe_end), 16'h0);
    rd(4'h1);
    chk("R7", "read dac", 16'(rd_byte), 16'h3C);
  endtask

  task automatic t_invalid;
    frame(8'h10, 8'hFF, 16, 1'b1);
    chk("R10", "reserved bits write ignored", 16'(cfg_out), 16'h5A);
    wr(4'h5, 8'h00);
    chk("R10", "unmapped write cfg", 16'(cfg_out), 16'h5A);
    chk("R10", "unmapped write dac", 16'(dac_code), 16'h3C);
    frame(8'h90, 8'h00, 16, 1'b1);
    chk("R10", "reserved bits read no drive", 16'(oe_any), 16'h0);
    rd(4'hF);
    chk("R10", "key read no drive", 16'(oe_any), 16'h0);
    rd(4'h2);
    chk("R10", "unmapped read no drive", 16'(oe_any), 16'h0);
    rd(4'h0);
    chk("R10", "still unlocked after ignored frames", 16'(rd_byte), 16'h5A);
  endtask

  task automatic t_abort;
    frame(8'h01, 8'h11, 12, 1'b1);
    chk("R5", "aborted write", 16'(dac_code), 16'h3C);
    frame(8'h80, 8'h00, 12, 1'b0);
    chk("R7", "drive during partial read", 16'(oe_any), 16'h1);
    cs_n = 1'b1; #HALF;
    chk("R8", "release on deselect", 16'(sdio_oe), 16'h0);
  endtask

  task automatic t_relock;
    wr(4'hF, 8'h12);
    rd(4'h0);
    chk("R6", "other key value relocks", 16'(oe_any), 16'h0);
    wr(4'hF, 8'hFE);
    wr(4'h1, 8'h77);
    wr(4'hF, 8'hED);
    rd(4'h0);
    chk("R6", "interrupted key stays locked", 16'(oe_any), 16'h0);
    chk("R4", "dac between keys", 16'(dac_code), 16'h77);
  endtask

  task automatic t_stream;
    frame(8'h0F, 8'hFE, 16, 1'b0);
    frame(8'h0F, 8'hED, 16, 1'b1);
    rd(4'h1);
    chk("R11", "back-to-back key frames", 16'(oe_all), 16'h1);
    chk("R11", "read after stream", 16'(rd_byte), 16'h77);
    frame(8'h00, 8'hFF, 5, 1'b1);
    wr(4'h0, 8'h3C);
    chk("R11", "restart after partial frame", 16'(cfg_out), 16'h3C);
  endtask

  initial begin
    #20 rst_n = 1'b1;
    #20;
    t_reset();
    t_write_cfg();
    t_write_dac();
    t_locked_read();
    t_unlock();
    t_invalid();
    t_abort();
    t_relock();
    t_stream();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule